// File: doc/BRIEF.md
# Shared Mailbox Ownership Controller

This block arbitrates a message mailbox that a host agent and a firmware agent share. The mailbox holds eight 64-bit data words, with a control word at the address just past them. The control word carries a 2-bit owner field and a message-valid flag. Only the agent that owns the mailbox may change the data words or the control word. A write from the other agent is dropped and reported with a busy pulse.

An agent claims a free mailbox by reading the control word. When both agents claim in the same cycle, firmware wins. The host fills the data words and then hands the message over: it writes the control word with the owner set to firmware and the valid flag set, and a one-cycle pulse tells firmware that a message is waiting. Firmware finishes by writing the owner back to host or to none, which clears the valid flag and raises a one-cycle interrupt pulse towards the host. Both agents may read the data words at any time for debug.

Top module: `mbox_own_ctrl`

## Requirements
- R1: After reset the owner is none (0), the valid flag is 0, every data word reads 0, and host_busy, fw_busy, fw_msg and host_irq are low.
- R2: Both read ports return data word N for address N (0 to 7) combinationally, whoever the owner is. Address 8 returns the control word: owner in bits 1:0, valid in bit 2, all other bits zero. Addresses 9 to 15 read as zero.
- R3: A data write (address 0 to 7) from an agent that is not the owner changes no word. That agent's busy output is high for exactly the one cycle after the write.
- R4: A data write from the owner (host encoding 2, firmware encoding 1) stores the word, and the new value is readable from the next cycle on. A write to addresses 9 to 15 has no effect and raises no busy pulse.
- R5: A read with the read enable set at address 8, while the owner is none, makes the reader the owner in the next cycle. The same read while the mailbox is owned leaves the owner unchanged.
- R6: When both agents claim a free mailbox in the same cycle, the owner becomes firmware (1).
- R7: An accepted control write from the host loads the owner field and the valid flag from the written bits. When it sets owner 1 with valid 1, fw_msg is high for exactly the next cycle.
- R8: An accepted control write from firmware that sets the owner to 0 or 2 clears the valid flag and pulses host_irq high for exactly the next cycle.
- R9: A control write from a non-owner, or one whose owner field is 3, is dropped and raises that agent's busy pulse in the next cycle.
- R10: The owner field never holds the value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_addr | input | 4 | Host write address (0-7 data, 8 control) |
| host_wr_data | input | 64 | Host write data |
| host_rd_en | input | 1 | Host read strobe (a read at address 8 claims the mailbox) |
| host_rd_addr | input | 4 | Host read address |
| host_rd_data | output | 64 | Host read data |
| fw_wr_en | input | 1 | Firmware write strobe |
| fw_wr_addr | input | 4 | Firmware write address |
| fw_wr_data | input | 64 | Firmware write data |
| fw_rd_en | input | 1 | Firmware read strobe (a read at address 8 claims the mailbox) |
| fw_rd_addr | input | 4 | Firmware read address |
| fw_rd_data | output | 64 | Firmware read data |
| owner_out | output | 2 | Current owner: 0 none, 1 firmware, 2 host |
| valid_out | output | 1 | Message-valid flag |
| host_busy | output | 1 | Rejected host write, one-cycle pulse |
| fw_busy | output | 1 | Rejected firmware write, one-cycle pulse |
| fw_msg | output | 1 | Host handoff to firmware, one-cycle pulse |
| host_irq | output | 1 | Firmware completion, one-cycle pulse |

## Verification
The assertions assume that each strobe is a clean single-cycle level sampled at the rising edge. They also assume that an agent does not claim and write the control word in the same cycle with the expectation that the write lands, because a claim only takes effect one cycle later. The stimulus drives every input at the falling edge and holds it for one full cycle, and it issues each write as a separate single-cycle operation. A reference model in the bench tracks owner, valid and the data words, so writes from a non-owner and control words with owner field 3 are exercised deliberately rather than avoided.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_FW   = 2'd1,
    OWN_HOST = 2'd2,
    OWN_UNK  = 2'd3
  } owner_e;

  localparam int CTRL_BITS = 3;
  localparam int VALID_POS = 2;

  // Control word layout: owner in [1:0], valid in [2].
  function automatic logic [CTRL_BITS-1:0] pack_ctrl(input owner_e own, input logic vld);
    return {vld, own};
  endfunction

  function automatic logic legal_owner(input logic [1:0] fld);
    return fld != OWN_UNK;
  endfunction

  // Firmware relinquishes when it hands the mailbox to anyone else.
  function automatic logic is_release(input logic [1:0] fld);
    return (fld == OWN_NONE) || (fld == OWN_HOST);
  endfunction

endpackage

// File: rtl/mbox_arbiter.sv
module mbox_arbiter
  import mbox_pkg::*;
#(
  parameter int WORDS  = 8,
  parameter int ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 h_wr,
  input  logic [ADDR_W-1:0]    h_addr,
  input  logic [CTRL_BITS-1:0] h_ctl,
  input  logic                 f_wr,
  input  logic [ADDR_W-1:0]    f_addr,
  input  logic [CTRL_BITS-1:0] f_ctl,
  input  logic                 h_claim,
  input  logic                 f_claim,
  output owner_e               owner_q,
  output logic                 valid_q,
  output logic                 h_data_we,
  output logic                 f_data_we,
  output logic                 h_busy_q,
  output logic                 f_busy_q,
  output logic                 msg_q,
  output logic                 irq_q
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(WORDS);

  logic h_is_data, h_is_ctl, f_is_data, f_is_ctl;
  logic h_own, f_own, h_ctl_ok, f_ctl_ok, h_rej, f_rej;
  logic handoff_ev, done_ev;
  owner_e owner_d;
  logic   valid_d;

  assign h_is_data = h_addr < CTRL_ADDR;
  assign h_is_ctl  = h_addr == CTRL_ADDR;
  assign f_is_data = f_addr < CTRL_ADDR;
  assign f_is_ctl  = f_addr == CTRL_ADDR;
  assign h_own     = owner_q == OWN_HOST;
  assign f_own     = owner_q == OWN_FW;

  assign h_data_we = h_wr & h_is_data & h_own;
  assign f_data_we = f_wr & f_is_data & f_own;
  assign h_ctl_ok  = h_wr & h_is_ctl & h_own & legal_owner(h_ctl[1:0]);
  assign f_ctl_ok  = f_wr & f_is_ctl & f_own & legal_owner(f_ctl[1:0]);
  assign h_rej     = h_wr & (h_is_data | h_is_ctl) & ~(h_data_we | h_ctl_ok);
  assign f_rej     = f_wr & (f_is_data | f_is_ctl) & ~(f_data_we | f_ctl_ok);

  assign handoff_ev = h_ctl_ok & (h_ctl[1:0] == OWN_FW) & h_ctl[VALID_POS];
  assign done_ev    = f_ctl_ok & is_release(f_ctl[1:0]);

  always_comb begin
    owner_d = owner_q;
    valid_d = valid_q;
    if (h_ctl_ok) begin
      owner_d = owner_e'(h_ctl[1:0]);
      valid_d = h_ctl[VALID_POS];
    end else if (f_ctl_ok) begin
      owner_d = owner_e'(f_ctl[1:0]);
      valid_d = done_ev ? 1'b0 : f_ctl[VALID_POS];
    end else if (owner_q == OWN_NONE) begin
      if (f_claim)      owner_d = OWN_FW;
      else if (h_claim) owner_d = OWN_HOST;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q  <= OWN_NONE;
      valid_q  <= 1'b0;
      h_busy_q <= 1'b0;
      f_busy_q <= 1'b0;
      msg_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      owner_q  <= owner_d;
      valid_q  <= valid_d;
      h_busy_q <= h_rej;
      f_busy_q <= f_rej;
      msg_q    <= handoff_ev;
      irq_q    <= done_ev;
    end
  end

endmodule

// File: rtl/mbox_store.sv
module mbox_store #(
  parameter int WORDS  = 8,
  parameter int DATA_W = 64,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_we,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_data,
  input  logic              f_we,
  input  logic [ADDR_W-1:0] f_addr,
  input  logic [DATA_W-1:0] f_data,
  output logic [DATA_W-1:0] word_q [WORDS]
);

  localparam int IDX_W = $clog2(WORDS);

  // Write enables are exclusive: only the single owner may write.
  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic hit_h, hit_f;
    assign hit_h = h_we && (h_addr[IDX_W-1:0] == IDX_W'(i));
    assign hit_f = f_we && (f_addr[IDX_W-1:0] == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)     word_q[i] <= '0;
      else if (hit_h) word_q[i] <= h_data;
      else if (hit_f) word_q[i] <= f_data;
    end
  end

endmodule

// File: rtl/mbox_own_ctrl.sv
module mbox_own_ctrl
  import mbox_pkg::*;
#(
  parameter int WORDS  = 8,
  parameter int DATA_W = 64,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [ADDR_W-1:0] host_wr_addr,
  input  logic [DATA_W-1:0] host_wr_data,
  input  logic              host_rd_en,
  input  logic [ADDR_W-1:0] host_rd_addr,
  output logic [DATA_W-1:0] host_rd_data,
  input  logic              fw_wr_en,
  input  logic [ADDR_W-1:0] fw_wr_addr,
  input  logic [DATA_W-1:0] fw_wr_data,
  input  logic              fw_rd_en,
  input  logic [ADDR_W-1:0] fw_rd_addr,
  output logic [DATA_W-1:0] fw_rd_data,
  output logic [1:0]        owner_out,
  output logic              valid_out,
  output logic              host_busy,
  output logic              fw_busy,
  output logic              fw_msg,
  output logic              host_irq
);

  localparam int IDX_W = $clog2(WORDS);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(WORDS);

  owner_e            owner_q;
  logic              h_data_we, f_data_we;
  logic              h_claim, f_claim;
  logic [DATA_W-1:0] word_q [WORDS];
  logic [DATA_W-1:0] ctrl_word;

  assign h_claim = host_rd_en && (host_rd_addr == CTRL_ADDR);
  assign f_claim = fw_rd_en && (fw_rd_addr == CTRL_ADDR);

  mbox_arbiter #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .h_wr      (host_wr_en),
    .h_addr    (host_wr_addr),
    .h_ctl     (host_wr_data[CTRL_BITS-1:0]),
    .f_wr      (fw_wr_en),
    .f_addr    (fw_wr_addr),
    .f_ctl     (fw_wr_data[CTRL_BITS-1:0]),
    .h_claim   (h_claim),
    .f_claim   (f_claim),
    .owner_q   (owner_q),
    .valid_q   (valid_out),
    .h_data_we (h_data_we),
    .f_data_we (f_data_we),
    .h_busy_q  (host_busy),
    .f_busy_q  (fw_busy),
    .msg_q     (fw_msg),
    .irq_q     (host_irq)
  );

  mbox_store #(.WORDS(WORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .h_we   (h_data_we),
    .h_addr (host_wr_addr),
    .h_data (host_wr_data),
    .f_we   (f_data_we),
    .f_addr (fw_wr_addr),
    .f_data (fw_wr_data),
    .word_q (word_q)
  );

  assign owner_out = owner_q;
  assign ctrl_word = DATA_W'(pack_ctrl(owner_q, valid_out));

  always_comb begin
    if (host_rd_addr < CTRL_ADDR)       host_rd_data = word_q[host_rd_addr[IDX_W-1:0]];
    else if (host_rd_addr == CTRL_ADDR) host_rd_data = ctrl_word;
    else                                host_rd_data = '0;
    if (fw_rd_addr < CTRL_ADDR)         fw_rd_data = word_q[fw_rd_addr[IDX_W-1:0]];
    else if (fw_rd_addr == CTRL_ADDR)   fw_rd_data = ctrl_word;
    else                                fw_rd_data = '0;
  end

endmodule

// File: rtl/mbox_own_checker.sv
module mbox_own_checker #(
  parameter int WORDS  = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr_en,
  input logic [ADDR_W-1:0] host_wr_addr,
  input logic [2:0]        host_ctl,
  input logic              fw_wr_en,
  input logic [ADDR_W-1:0] fw_wr_addr,
  input logic [1:0]        fw_ctl,
  input logic              host_rd_en,
  input logic [ADDR_W-1:0] host_rd_addr,
  input logic              fw_rd_en,
  input logic [ADDR_W-1:0] fw_rd_addr,
  input logic [1:0]        owner_out,
  input logic              valid_out,
  input logic              host_busy,
  input logic              fw_busy,
  input logic              fw_msg,
  input logic              host_irq,
  input logic              h_data_we,
  input logic              f_data_we
);

  localparam logic [ADDR_W-1:0] CA = ADDR_W'(WORDS);

  p_owner_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    owner_out != 2'd3);

  p_host_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_en && host_wr_addr < CA && owner_out != 2'd2) |=> host_busy);

  p_fw_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_wr_en && fw_wr_addr < CA && owner_out != 2'd1) |=> fw_busy);

  p_host_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    h_data_we |-> owner_out == 2'd2);

  p_fw_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    f_data_we |-> owner_out == 2'd1);

  p_claim_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_out == 2'd0 && host_rd_en && host_rd_addr == CA && fw_rd_en && fw_rd_addr == CA)
    |=> owner_out == 2'd1);

  p_handoff_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_out == 2'd2 && host_wr_en && host_wr_addr == CA && host_ctl == 3'b101)
    |=> (owner_out == 2'd1 && valid_out && fw_msg));

  p_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_out == 2'd1 && fw_wr_en && fw_wr_addr == CA && (fw_ctl == 2'd0 || fw_ctl == 2'd2))
    |=> (!valid_out && host_irq));

  p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |=> !host_irq);

endmodule

bind mbox_own_ctrl mbox_own_checker #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_wr_en   (host_wr_en),
  .host_wr_addr (host_wr_addr),
  .host_ctl     (host_wr_data[2:0]),
  .fw_wr_en     (fw_wr_en),
  .fw_wr_addr   (fw_wr_addr),
  .fw_ctl       (fw_wr_data[1:0]),
  .host_rd_en   (host_rd_en),
  .host_rd_addr (host_rd_addr),
  .fw_rd_en     (fw_rd_en),
  .fw_rd_addr   (fw_rd_addr),
  .owner_out    (owner_out),
  .valid_out    (valid_out),
  .host_busy    (host_busy),
  .fw_busy      (fw_busy),
  .fw_msg       (fw_msg),
  .host_irq     (host_irq),
  .h_data_we    (h_data_we),
  .f_data_we    (f_data_we)
);

// File: tb/mbox_own_ctrl_test.sv
module mbox_own_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0, fw_wr_en = 1'b0, host_rd_en = 1'b0, fw_rd_en = 1'b0;
  logic [3:0]  host_wr_addr = '0, fw_wr_addr = '0, host_rd_addr = '0, fw_rd_addr = '0;
  logic [63:0] host_wr_data = '0, fw_wr_data = '0;
  logic [63:0] host_rd_data, fw_rd_data;
  logic [1:0]  owner_out;
  logic        valid_out, host_busy, fw_busy, fw_msg, host_irq;

  int errors = 0;
  int checks = 0;

  logic [1:0]  m_own;
  logic        m_val;
  logic [63:0] m_mem [8];

  always #5 clk = ~clk;

  mbox_own_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
    .host_rd_en(host_rd_en), .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data),
    .fw_wr_en(fw_wr_en), .fw_wr_addr(fw_wr_addr), .fw_wr_data(fw_wr_data),
    .fw_rd_en(fw_rd_en), .fw_rd_addr(fw_rd_addr), .fw_rd_data(fw_rd_data),
    .owner_out(owner_out), .valid_out(valid_out), .host_busy(host_busy),
    .fw_busy(fw_busy), .fw_msg(fw_msg), .host_irq(host_irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Compare every port-visible piece of state against the model.
  task automatic compare_all(input logic eb_h, input logic eb_f, input logic e_msg, input logic e_irq);
    chk("R5/R6/R7/R8 owner", 64'(owner_out), 64'(m_own));
    chk("R10 owner legal", 64'(owner_out == 2'd3), 64'd0);
    chk("R7/R8 valid", 64'(valid_out), 64'(m_val));
    chk("R3/R9 host_busy", 64'(host_busy), 64'(eb_h));
    chk("R3/R9 fw_busy", 64'(fw_busy), 64'(eb_f));
    chk("R7 fw_msg", 64'(fw_msg), 64'(e_msg));
    chk("R8 host_irq", 64'(host_irq), 64'(e_irq));
    for (int a = 0; a < 10; a++) begin
      host_rd_addr = 4'(a);
      fw_rd_addr   = 4'(9 - a);
      #1;
      chk("R2/R4 host read", host_rd_data,
          (a < 8) ? m_mem[a] : (a == 8) ? {61'd0, m_val, m_own} : 64'd0);
      chk("R2/R4 fw read", fw_rd_data,
          ((9 - a) < 8) ? m_mem[9 - a] : ((9 - a) == 8) ? {61'd0, m_val, m_own} : 64'd0);
    end
  endtask

  task automatic step(input logic hw, input logic [3:0] ha, input logic [63:0] hd,
                      input logic fw, input logic [3:0] fa, input logic [63:0] fd,
                      input logic hc, input logic fc);
    logic eb_h, eb_f, e_msg, e_irq;
    logic [1:0] n_own;
    logic n_val;
    @(negedge clk);
    host_wr_en = hw; host_wr_addr = ha; host_wr_data = hd;
    fw_wr_en = fw; fw_wr_addr = fa; fw_wr_data = fd;
    host_rd_en = hc; fw_rd_en = fc;
    host_rd_addr = hc ? 4'd8 : 4'd0;
    fw_rd_addr   = fc ? 4'd8 : 4'd0;
    eb_h = 0; eb_f = 0; e_msg = 0; e_irq = 0;
    n_own = m_own; n_val = m_val;
    if (hw && ha < 8) begin
      if (m_own == 2'd2) m_mem[ha[2:0]] = hd; else eb_h = 1;
    end
    if (fw && fa < 8) begin
      if (m_own == 2'd1) m_mem[fa[2:0]] = fd; else eb_f = 1;
    end
    if (hw && ha == 8) begin
      if (m_own == 2'd2 && hd[1:0] != 2'd3) begin
        n_own = hd[1:0]; n_val = hd[2];
        e_msg = (hd[1:0] == 2'd1) && hd[2];
      end else eb_h = 1;
    end
    if (fw && fa == 8) begin
      if (m_own == 2'd1 && fd[1:0] != 2'd3) begin
        n_own = fd[1:0];
        if (fd[1:0] != 2'd1) begin n_val = 0; e_irq = 1; end
        else n_val = fd[2];
      end else eb_f = 1;
    end
    if (m_own == 2'd0) begin
      if (fc) n_own = 2'd1;
      else if (hc) n_own = 2'd2;
    end
    m_own = n_own; m_val = n_val;
    @(negedge clk);
    host_wr_en = 0; fw_wr_en = 0; host_rd_en = 0; fw_rd_en = 0;
    compare_all(eb_h, eb_f, e_msg, e_irq);
  endtask

  task automatic hwr(input logic [3:0] a, input logic [63:0] d); step(1, a, d, 0, 0, 0, 0, 0); endtask
  task automatic fwr(input logic [3:0] a, input logic [63:0] d); step(0, 0, 0, 1, a, d, 0, 0); endtask

  task automatic set_owner(input int t);
    if (m_own == 2'd1) fwr(4'd8, 64'd0);
    if (m_own == 2'd2) hwr(4'd8, 64'd0);
    if (t == 1) step(0, 0, 0, 0, 0, 0, 0, 1);
    if (t == 2) step(0, 0, 0, 0, 0, 0, 1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_own = 0; m_val = 0;
    for (int i = 0; i < 8; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    compare_all(0, 0, 0, 0);

    // R3, R4, R9: every owner state x every address x each writer
    for (int own = 0; own < 3; own++)
      for (int a = 0; a < 10; a++)
        for (int ag = 0; ag < 2; ag++) begin
          logic [63:0] pat;
          pat = {32'hC0DE_0000 | 32'(own * 256 + a * 4 + ag), ~32'(a * 977 + own)};
          set_owner(own);
          if (ag == 0) hwr(4'(a), pat); else fwr(4'(a), pat);
        end

    // R7, R8, R9: every control encoding from every owner state and writer
    for (int own = 0; own < 3; own++)
      for (int f = 0; f < 8; f++)
        for (int ag = 0; ag < 2; ag++) begin
          set_owner(own);
          if (ag == 0) hwr(4'd8, 64'(f)); else fwr(4'd8, 64'(f));
        end

    // R6: simultaneous claim on a free mailbox
    set_owner(0);
    step(0, 0, 0, 0, 0, 0, 1, 1);
    // R5: claims while owned do nothing
    step(0, 0, 0, 0, 0, 0, 1, 0);
    set_owner(2);
    step(0, 0, 0, 0, 0, 0, 0, 1);

    // R7 then R8: full message round trip
    for (int i = 0; i < 8; i++) hwr(4'(i), 64'h1111_0000_0000_0000 + 64'(i));
    hwr(4'd8, 64'd5);
    fwr(4'd3, 64'hFEED_FACE_0000_0003);
    fwr(4'd8, 64'd2);
    step(0, 0, 0, 0, 0, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule